// File: doc/BRIEF.md
# Read-to-Accept Priority Interrupt Controller

This block collects a set of level-sensitive interrupt lines, each with a 4-bit priority set by software, and drives one request line toward the processor. A line is eligible when it is asserted and its priority is strictly above the current level held in the block. The request output is high while any line is eligible.

Reading the flag register accepts a source and changes state, all in one clock edge. The current level is copied into the previous-level register. The eligible line with the highest priority wins. The current level is raised to the winner's priority. The winner's vector code is stored in both the flag register and the event register, and it is also returned as the read data.

When the handler has finished, software writes the saved previous level back into the current-level register. A flag read that finds no eligible line returns zero, which marks a spurious vector. The bus is a single-cycle strobe interface: reads are combinational and writes commit on the clock edge.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset all priorities, the current and previous levels, the flag register and the event register read as zero, and `irq_out` is low.
- R2: A read at offset 0x18 returns the vector of the eligible source with the highest priority; when priorities are equal the lowest-numbered source wins. The vector for source n is (n+16)<<5, so vectors start at 0x200 and are spaced 0x20 apart.
- R3: A source is eligible only when its line is high and its priority is strictly greater than the current level (offset 0x30). A priority of 0 never makes a source eligible.
- R4: Every read at 0x18 copies the current level into the previous-level register (offset 0x34, bits [3:0]) on that clock edge.
- R5: A read at 0x18 that accepts a source loads the current level with that source's priority.
- R6: The accepted vector is stored in the event register (offset 0x20) and the flag register. The event register keeps its value through any other access until the next read at 0x18.
- R7: A read at 0x18 with no eligible source returns 0, writes 0 into the event and flag registers, leaves the current level unchanged, and still performs the level copy of R4.
- R8: A write to offset 0x30 loads the current level from wdata[3:0]. The bits above bit 3 are ignored and read back as zero.
- R9: `irq_out` is high exactly when at least one source is eligible under R3.
- R10: The priority of source n lives in the word at offset 0x40 + 4*(n/8), bits [4*(n%8)+3 : 4*(n%8)]. Those words are written whole and can be read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Level-sensitive interrupt lines, one per source |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, committed at the clock edge |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a read at 0x18 has side effects |
| rdata | output | 32 | Read data (combinational; 0 when rd_en is low) |
| irq_out | output | 1 | Interrupt request toward the processor |

## Verification
The bound checker watches every flag read on every cycle. It checks that the level copy happens, that the event register is held between flag reads, and that a spurious read clears both vector registers. It also checks that an accepted vector has the required form and raises the level, and that read data agrees with `irq_out`. Only the bench's scenarios can show that the right source wins: this covers tie breaking between equal priorities, nesting above a raised level, the level being restored by a write, and the packing of the priority words. Each of those needs a known set of priorities and known expected values.

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl #(
  parameter int NSRC  = 32,
  parameter int PW    = 4,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  input  logic            rd_en,
  output logic [DW-1:0]   rdata,
  output logic            irq_out
);

  localparam int IW        = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int PER_WORD  = DW / PW;
  localparam int PRI_WORDS = (NSRC + PER_WORD - 1) / PER_WORD;
  localparam logic [AW-1:0] A_FLAG = AW'(8'h18);
  localparam logic [AW-1:0] A_EVT  = AW'(8'h20);
  localparam logic [AW-1:0] A_CUR  = AW'(8'h30);
  localparam logic [AW-1:0] A_PREV = AW'(8'h34);
  localparam int PRI_BASE = 'h40;
  localparam int VEC_OFS  = 16;
  localparam int VEC_SH   = 5;

  logic [PW-1:0] pri [NSRC];
  logic [PW-1:0] cur_lvl, prev_lvl;
  logic [DW-1:0] flag_vec, evt_vec;

  logic          win_any;
  logic [IW-1:0] win_idx;
  logic [PW-1:0] win_pri;
  logic [DW-1:0] win_vec;
  logic [DW-1:0] pri_word [PRI_WORDS];
  logic          flag_rd;

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    win_pri = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (irq_in[i] && pri[i] > cur_lvl && (!win_any || pri[i] > win_pri)) begin
        win_any = 1'b1;
        win_idx = IW'(i);
        win_pri = pri[i];
      end
    end
  end

  assign win_vec = win_any ? ((DW'(win_idx) + DW'(VEC_OFS)) << VEC_SH) : '0;
  assign irq_out = win_any;
  assign flag_rd = rd_en && addr == A_FLAG;

  always_comb begin
    for (int w = 0; w < PRI_WORDS; w++) begin
      pri_word[w] = '0;
      for (int s = 0; s < PER_WORD; s++) begin
        if (w * PER_WORD + s < NSRC)
          pri_word[w][s*PW +: PW] = pri[w * PER_WORD + s];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_FLAG:  rdata = win_vec;
        A_EVT:   rdata = evt_vec;
        A_CUR:   rdata = DW'(cur_lvl);
        A_PREV:  rdata = DW'(prev_lvl);
        default: begin
          for (int w = 0; w < PRI_WORDS; w++)
            if (addr == AW'(PRI_BASE + 4 * w)) rdata = pri_word[w];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl  <= '0;
      prev_lvl <= '0;
      flag_vec <= '0;
      evt_vec  <= '0;
    end else if (flag_rd) begin
      prev_lvl <= cur_lvl;
      flag_vec <= win_vec;
      evt_vec  <= win_vec;
      if (win_any) cur_lvl <= win_pri;
    end else if (wr_en && addr == A_CUR) begin
      cur_lvl <= wdata[PW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) pri[i] <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < PRI_WORDS; w++)
        if (addr == AW'(PRI_BASE + 4 * w))
          for (int s = 0; s < PER_WORD; s++)
            if (w * PER_WORD + s < NSRC)
              pri[w * PER_WORD + s] <= wdata[s*PW +: PW];
    end
  end

endmodule

// File: rtl/irq_accept_ctrl_chk.sv
module irq_accept_ctrl_chk #(
  parameter int PW = 4,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd_en,
  input logic [DW-1:0] rdata,
  input logic          irq_out,
  input logic [PW-1:0] cur_lvl,
  input logic [PW-1:0] prev_lvl,
  input logic [DW-1:0] evt_vec,
  input logic [DW-1:0] flag_vec
);

  logic flag_rd;
  assign flag_rd = rd_en && addr == AW'(8'h18);

  a_r4_prev_copy: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd |=> prev_lvl == $past(cur_lvl));

  a_r6_evt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_rd |=> $stable(evt_vec) && $stable(flag_vec));

  a_r6_evt_load: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd |=> evt_vec == $past(rdata) && flag_vec == $past(rdata));

  a_r7_spurious_keep_lvl: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && rdata == '0) |=> cur_lvl == $past(cur_lvl));

  a_r5_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && rdata != '0) |=> cur_lvl > $past(cur_lvl));

  a_r2_vec_form: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && rdata != '0) |-> rdata[4:0] == 5'd0 && rdata >= DW'(32'h200));

  a_r9_irq_matches_read: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd |-> (rdata != '0) == irq_out);

endmodule

bind irq_accept_ctrl irq_accept_ctrl_chk #(.PW(PW), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .rdata(rdata),
  .irq_out(irq_out), .cur_lvl(cur_lvl), .prev_lvl(prev_lvl),
  .evt_vec(evt_vec), .flag_vec(flag_vec)
);

// File: tb/sim_irq_accept_ctrl.sv
module sim_irq_accept_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] irq_in = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 0;
  logic [31:0] wdata = '0;
  logic        rd_en = 0;
  logic [31:0] rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] pri_sh [32];

  irq_accept_ctrl u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1;
    #1 d = rdata;
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic set_pri(int src, logic [3:0] p);
    logic [31:0] w;
    pri_sh[src] = p;
    w = '0;
    for (int s = 0; s < 8; s++) w[s*4 +: 4] = pri_sh[(src/8)*8 + s];
    bus_wr(8'(8'h40 + 4*(src/8)), w);
  endtask

  function automatic logic [31:0] vec(int n);
    return 32'((n + 16) << 5);
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq_out", {31'b0, irq_out}, 0);
    bus_rd(8'h30, d); check("R1 cur", d, 0);
    bus_rd(8'h34, d); check("R1 prev", d, 0);
    bus_rd(8'h20, d); check("R1 evt", d, 0);
    for (int w = 0; w < 4; w++) begin
      bus_rd(8'(8'h40 + 4*w), d); check("R1 pri", d, 0);
    end
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    irq_in[7] = 1; #1;
    check("R3 prio0 no irq", {31'b0, irq_out}, 0);
    bus_rd(8'h18, d); check("R7 spurious zero", d, 0);
    irq_in[7] = 0;
  endtask

  task automatic t_layout;
    logic [31:0] d;
    set_pri(13, 4'hA);
    bus_rd(8'h44, d); check("R10 word1", d, 32'h00A0_0000);
    set_pri(13, 4'h0);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    set_pri(5, 3);
    irq_in[5] = 1; #1;
    check("R9 irq high", {31'b0, irq_out}, 1);
    bus_rd(8'h18, d); check("R2 vec src5", d, vec(5));
    bus_rd(8'h30, d); check("R5 cur=3", d, 3);
    bus_rd(8'h34, d); check("R4 prev=0", d, 0);
    bus_rd(8'h20, d); check("R6 evt", d, vec(5));
    check("R3 equal level blocks", {31'b0, irq_out}, 0);
  endtask

  task automatic t_nest;
    logic [31:0] d;
    set_pri(9, 7);
    irq_in[9] = 1; #1;
    check("R9 nested irq", {31'b0, irq_out}, 1);
    bus_rd(8'h18, d); check("R2 vec src9", d, vec(9));
    bus_rd(8'h34, d); check("R4 prev=3", d, 3);
    bus_rd(8'h30, d); check("R5 cur=7", d, 7);
    irq_in[9] = 0;
    bus_wr(8'h30, 32'hFFFF_FFF3);
    bus_rd(8'h30, d); check("R8 restore", d, 3);
    bus_rd(8'h20, d); check("R6 evt held", d, vec(9));
  endtask

  task automatic t_spurious;
    logic [31:0] d;
    bus_rd(8'h18, d); check("R7 ret zero", d, 0);
    bus_rd(8'h20, d); check("R7 evt zero", d, 0);
    bus_rd(8'h30, d); check("R7 cur kept", d, 3);
    bus_rd(8'h34, d); check("R7 prev copied", d, 3);
    irq_in[5] = 0;
  endtask

  task automatic t_tie;
    logic [31:0] d;
    bus_wr(8'h30, 0);
    set_pri(2, 5); set_pri(30, 5); set_pri(12, 4);
    irq_in[2] = 1; irq_in[30] = 1; irq_in[12] = 1;
    bus_rd(8'h18, d); check("R2 tie lowest", d, vec(2));
    bus_rd(8'h18, d); check("R3 above 5 none", d, 0);
    bus_wr(8'h30, 0);
    irq_in[2] = 0;
    bus_rd(8'h18, d); check("R2 next src30", d, vec(30));
    irq_in = '0;
  endtask

  task automatic t_extremes;
    logic [31:0] d;
    bus_wr(8'h30, 0);
    set_pri(0, 14); set_pri(31, 15);
    irq_in[0] = 1; irq_in[31] = 1;
    bus_rd(8'h18, d); check("R2 src31 max", d, vec(31));
    bus_rd(8'h30, d); check("R5 cur=15", d, 15);
    check("R9 none above 15", {31'b0, irq_out}, 0);
    bus_wr(8'h30, 0);
    irq_in[31] = 0;
    bus_rd(8'h18, d); check("R2 src0", d, 32'h200);
    irq_in = '0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) pri_sh[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_disabled();
    t_layout();
    t_basic();
    t_nest();
    t_spurious();
    t_tie();
    t_extremes();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule